// File: doc/BRIEF.md
# Programmable Interval Timer With Wrap Overflow

This block counts a slow, fixed-rate tick strobe (nominally 100 kHz, delivered as a one-cycle enable on the system clock) in a 12-bit up counter. When the counter equals a 12-bit period value, it raises a done flag and starts again from zero. Software can set a period below the value already counted. In that case the counter runs on to its all-ones value, rolls to zero and raises a separate overflow flag. It keeps counting after the roll, so a later equality match still raises the done flag.

Software drives one control write. That write carries a run bit, a counter-clear bit, a flag-clear bit and a new 12-bit period. A second write port holds a 3-bit interrupt priority code. The block presents a packed status word and an interrupt request that stays high while either flag is set.

A two-state controller with states OFF and COUNT owns the run/stop behaviour. A control write with the run bit at 1 takes OFF to COUNT (transition START). A control write with the run bit at 0 takes COUNT back to OFF (transition STOP). In COUNT, each tick is classified as STEP (add one), MATCH (equality, clear the counter, set done) or WRAP (all-ones without equality, clear the counter, set overflow). In OFF, every tick is classified as HOLD.

Top module: `ivt_timer`

## Requirements
- R1: After reset the counter and period are zero, the timer is in OFF, both flags are clear, the priority code is zero and irq_req is low.
- R2: A control write (ctl_wr=1) loads ctl_period into the period register and ctl_run into the run state. Both take effect on the next clock edge. The period compared on that same edge is the old one.
- R3: In COUNT, a cycle with tick_en=1 where the counter neither equals the period nor is 4095 adds one to the counter. A cycle with tick_en=0 leaves the counter unchanged.
- R4: In COUNT, a tick when the counter equals the period sets the done flag and loads zero into the counter on the same edge. With period 0, every tick matches.
- R5: In COUNT, a tick when the counter is 4095 and the period is not 4095 sets the overflow flag and loads zero into the counter. Counting then continues, so a later match sets done. When the period is 4095, the tick at 4095 is a match, not an overflow.
- R6: A control write with ctl_clr_cnt=1 loads zero into the counter on the next edge. This overrides any tick action on that edge, and it works in OFF as well.
- R7: A control write with ctl_clr_flags=1 clears both flags. If a tick on the same edge sets a flag, that flag ends up set.
- R8: In OFF, ticks change neither the counter nor the flags.
- R9: irq_req is 1 exactly when done or overflow is set. irq_prio shows the value last written through prio_wr, and the priority write has no effect on counting.
- R10: The status word layout is: bits 26:15 counter, bit 14 run, bit 13 done, bit 12 overflow, bits 11:0 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe at the counting rate |
| ctl_wr | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run (1) or stop (0) the timer |
| ctl_clr_cnt | input | 1 | Clear the up counter |
| ctl_clr_flags | input | 1 | Clear done and overflow |
| ctl_period | input | 12 | New period value |
| prio_wr | input | 1 | Priority write strobe |
| prio_data | input | 3 | New interrupt priority code |
| status | output | 27 | Packed counter, run, done, overflow, period |
| irq_req | output | 1 | Interrupt request |
| irq_prio | output | 3 | Interrupt priority code |

## Verification
A wrong controller state or a wrong tick classification shows up in the status word on the very next edge. It appears as a counter that fails to step, fails to hold or fails to clear, or as a flag that rises on the wrong tick. A fault in the wrap path may need up to 4096 ticks before the counter reaches all-ones, so the stimulus deliberately drives the counter past a lowered period to reach that point. A lost flag set during a simultaneous clear shows at irq_req in the same cycle the status updates.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic {
        ST_OFF   = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_MATCH = 2'd2,
        ACT_WRAP  = 2'd3
    } tick_act_e;
endpackage

// File: rtl/ivt_fsm.sv
module ivt_fsm
    import ivt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic      ctl_run,
    input  logic      tick_en,
    input  logic      cnt_eq,
    input  logic      cnt_max,
    output logic      running,
    output tick_act_e act
);
    tmr_state_e state_q;
    tmr_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions: START (OFF->COUNT), STOP (COUNT->OFF)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (ctl_wr && ctl_run)  state_d = ST_COUNT;
            ST_COUNT: if (ctl_wr && !ctl_run) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // outputs: tick classification
    always_comb begin
        running = 1'b0;
        act     = ACT_HOLD;
        unique case (state_q)
            ST_OFF: begin
                running = 1'b0;
                act     = ACT_HOLD;
            end
            ST_COUNT: begin
                running = 1'b1;
                if (tick_en) begin
                    if (cnt_eq)       act = ACT_MATCH;
                    else if (cnt_max) act = ACT_WRAP;
                    else              act = ACT_STEP;
                end
            end
            default: begin
                running = 1'b0;
                act     = ACT_HOLD;
            end
        endcase
    end
endmodule

// File: rtl/ivt_count.sv
module ivt_count
    import ivt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  tick_act_e        act,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_eq,
    output logic             cnt_max
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign cnt_eq  = (cnt == period);
    assign cnt_max = &cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            unique case (act)
                ACT_STEP:  cnt <= cnt + ONE;
                ACT_MATCH: cnt <= '0;
                ACT_WRAP:  cnt <= '0;
                default:   cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/ivt_flags.sv
module ivt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_ovf,
    input  logic clr,
    output logic done,
    output logic ovf
);
    // a set on the same edge as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (set_done)  done <= 1'b1;
            else if (clr)  done <= 1'b0;
            if (set_ovf)   ovf  <= 1'b1;
            else if (clr)  ovf  <= 1'b0;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PRIO_W = 3,
    localparam int STAT_W = 2 * CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ctl_wr,
    input  logic              ctl_run,
    input  logic              ctl_clr_cnt,
    input  logic              ctl_clr_flags,
    input  logic [CNT_W-1:0]  ctl_period,
    input  logic              prio_wr,
    input  logic [PRIO_W-1:0] prio_data,
    output logic [STAT_W-1:0] status,
    output logic              irq_req,
    output logic [PRIO_W-1:0] irq_prio
);
    logic [CNT_W-1:0]  period_q;
    logic [PRIO_W-1:0] prio_q;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_eq;
    logic              cnt_max;
    logic              running;
    tick_act_e         act;
    logic              done;
    logic              ovf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            prio_q   <= '0;
        end else begin
            if (ctl_wr)  period_q <= ctl_period;
            if (prio_wr) prio_q   <= prio_data;
        end
    end

    ivt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .ctl_run (ctl_run),
        .tick_en (tick_en),
        .cnt_eq  (cnt_eq),
        .cnt_max (cnt_max),
        .running (running),
        .act     (act)
    );

    ivt_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctl_wr && ctl_clr_cnt),
        .act     (act),
        .period  (period_q),
        .cnt     (cnt),
        .cnt_eq  (cnt_eq),
        .cnt_max (cnt_max)
    );

    ivt_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (act == ACT_MATCH),
        .set_ovf  (act == ACT_WRAP),
        .clr      (ctl_wr && ctl_clr_flags),
        .done     (done),
        .ovf      (ovf)
    );

    assign status   = {cnt, running, done, ovf, period_q};
    assign irq_req  = done | ovf;
    assign irq_prio = prio_q;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int CNT_W  = 12,
    parameter int PRIO_W = 3,
    localparam int STAT_W = 2 * CNT_W + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              ctl_wr,
    input logic              ctl_run,
    input logic              ctl_clr_cnt,
    input logic              ctl_clr_flags,
    input logic [CNT_W-1:0]  ctl_period,
    input logic              prio_wr,
    input logic [PRIO_W-1:0] prio_data,
    input logic [STAT_W-1:0] status,
    input logic              irq_req,
    input logic [PRIO_W-1:0] irq_prio
);
    logic [CNT_W-1:0] c_cnt;
    logic [CNT_W-1:0] c_per;
    logic             c_run;
    logic             c_done;
    logic             c_ovf;
    logic             c_clr;

    assign c_cnt  = status[STAT_W-1 -: CNT_W];
    assign c_run  = status[CNT_W+2];
    assign c_done = status[CNT_W+1];
    assign c_ovf  = status[CNT_W];
    assign c_per  = status[CNT_W-1:0];
    assign c_clr  = ctl_wr && ctl_clr_cnt;

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_run && tick_en && !c_clr && (c_cnt != c_per) && !(&c_cnt)
        |=> c_cnt == $past(c_cnt) + CNT_W'(1));

    p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_run && tick_en && (c_cnt == c_per) |=> c_done && (c_cnt == '0));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_run && tick_en && (&c_cnt) && !(&c_per) |=> c_ovf && (c_cnt == '0));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr |=> c_cnt == '0);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_run && tick_en && (c_cnt == c_per) && ctl_wr && ctl_clr_flags |=> c_done);

    p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !c_run && !c_clr |=> $stable(c_cnt));

    p_off_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !c_run && !(ctl_wr && ctl_clr_flags) |=> $stable(c_done) && $stable(c_ovf));

    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (c_done || c_ovf));

    p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prio_wr |=> irq_prio == $past(prio_data));
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/ivt_timer_tb.sv
`timescale 1ns/1ps
module ivt_timer_tb;
    localparam int W = 12;
    localparam logic [W-1:0] MAXV = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic ctl_wr = 1'b0;
    logic ctl_run = 1'b0;
    logic ctl_clr_cnt = 1'b0;
    logic ctl_clr_flags = 1'b0;
    logic [W-1:0] ctl_period = '0;
    logic prio_wr = 1'b0;
    logic [2:0] prio_data = '0;
    logic [2*W+2:0] status;
    logic irq_req;
    logic [2:0] irq_prio;

    int n_tests = 0;
    int n_fail = 0;

    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_per = '0;
    logic m_run = 1'b0;
    logic m_done = 1'b0;
    logic m_ovf = 1'b0;
    logic [2:0] m_prio = '0;

    always #2.5 clk = ~clk;

    ivt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_wr(ctl_wr),
        .ctl_run(ctl_run), .ctl_clr_cnt(ctl_clr_cnt), .ctl_clr_flags(ctl_clr_flags),
        .ctl_period(ctl_period), .prio_wr(prio_wr), .prio_data(prio_data),
        .status(status), .irq_req(irq_req), .irq_prio(irq_prio)
    );

    function automatic logic [2*W+2:0] pack_status();
        return {m_cnt, m_run, m_done, m_ovf, m_per};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [2*W+2:0] e;
        e = pack_status();
        n_tests++;
        if (status !== e || irq_req !== (m_done | m_ovf) || irq_prio !== m_prio) begin
            n_fail++;
            $display("FAIL %s/R10: status %0h irq %0b prio %0d expected %0h %0b %0d",
                     tag, status, irq_req, irq_prio, e, m_done | m_ovf, m_prio);
        end
    endtask

    // model update at the edge, from the requirements
    task automatic model_edge();
        logic match, wrap, stp;
        match = m_run && tick_en && (m_cnt == m_per);
        wrap  = m_run && tick_en && !match && (m_cnt == MAXV);
        stp   = m_run && tick_en && !match && !wrap;
        if (ctl_wr && ctl_clr_cnt) m_cnt = '0;
        else if (match || wrap)    m_cnt = '0;
        else if (stp)              m_cnt = m_cnt + 1'b1;
        if (match) m_done = 1'b1; else if (ctl_wr && ctl_clr_flags) m_done = 1'b0;
        if (wrap)  m_ovf  = 1'b1; else if (ctl_wr && ctl_clr_flags) m_ovf  = 1'b0;
        if (ctl_wr) begin
            m_per = ctl_period;
            m_run = ctl_run;
        end
        if (prio_wr) m_prio = prio_data;
    endtask

    task automatic cyc(input logic t, input logic w, input logic run, input logic cc,
                       input logic cf, input logic [W-1:0] p, input logic pw,
                       input logic [2:0] pd, input string tag);
        @(negedge clk);
        tick_en = t; ctl_wr = w; ctl_run = run; ctl_clr_cnt = cc;
        ctl_clr_flags = cf; ctl_period = p; prio_wr = pw; prio_data = pd;
        @(posedge clk);
        model_edge();
        #1;
        check_all(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1 reset");
        check("R1 irq after reset", {31'd0, irq_req}, 32'd0);

        // R2/R3: start with period 3
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'd3, 1'b0, '0, "R2 load");
        check("R2 period field", {20'd0, status[11:0]}, 32'd3);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R3 no tick");
        ticks(3, "R3 step");
        check("R3 count 3", {20'd0, status[26:15]}, 32'd3);
        ticks(1, "R4 match");
        check("R4 done set", {31'd0, status[13]}, 32'd1);
        check("R4 counter zero", {20'd0, status[26:15]}, 32'd0);

        // R7: period 0, clear flags while a match sets done
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'd0, 1'b0, '0, "R7 clear");
        check("R7 flags cleared", {30'd0, status[13:12]}, 32'd0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 12'd0, 1'b0, '0, "R7 set wins");
        check("R7 done kept", {31'd0, status[13]}, 32'd1);

        // R8: off, ticks do nothing
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'd50, 1'b0, '0, "R8 prep");
        ticks(5, "R8 prep");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd2, 1'b0, '0, "R8 stop");
        ticks(10, "R8 off");
        check("R8 counter held", {20'd0, status[26:15]}, 32'd5);
        check("R8 flags held", {30'd0, status[13:12]}, 32'd0);

        // R6: clear counter overrides a tick, also in OFF
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'd2, 1'b0, '0, "R6 off clear");
        check("R6 cleared", {20'd0, status[26:15]}, 32'd0);

        // R5: count to 100 with period 4095, lower period to 2, wrap
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, MAXV, 1'b0, '0, "R5 prep");
        ticks(100, "R5 prep");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'd2, 1'b0, '0, "R5 lower");
        ticks(4095 - 100, "R5 climb");
        check("R5 at max", {20'd0, status[26:15]}, 32'h0fff);
        ticks(1, "R5 wrap");
        check("R5 overflow set", {31'd0, status[12]}, 32'd1);
        check("R5 done clear", {31'd0, status[13]}, 32'd0);
        ticks(3, "R5 continue");
        check("R5 later match", {31'd0, status[13]}, 32'd1);

        // R5: period 4095 is a match, not overflow
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, MAXV, 1'b0, '0, "R5 max prep");
        ticks(4096, "R5 max period");
        check("R5 max done", {31'd0, status[13]}, 32'd1);
        check("R5 max no ovf", {31'd0, status[12]}, 32'd0);

        // R6 with tick while running
        ticks(7, "R6 prep");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, MAXV, 1'b0, '0, "R6 run clear");
        check("R6 run cleared", {20'd0, status[26:15]}, 32'd0);

        // R9: priority
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 3'd5, "R9 prio");
        check("R9 prio value", {29'd0, irq_prio}, 32'd5);
        check("R9 irq with done", {31'd0, irq_req}, 32'd1);

        // random mix
        for (int i = 0; i < 30000; i++) begin
            logic w;
            w = ($urandom % 16) == 0;
            cyc(($urandom % 3) != 0, w, ($urandom % 8) != 0,
                ($urandom % 4) == 0, ($urandom % 3) == 0,
                (($urandom % 4) == 0) ? W'($urandom) : W'($urandom % 24),
                ($urandom % 32) == 0, 3'($urandom), "R3 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule